// File: doc/BRIEF.md
# Hardware Semaphore Lock Pool

This block holds a small pool of hardware semaphores shared by several processor cores. An external time-slot arbiter serialises the cores' accesses, so the block sees at most one request per clock cycle. A request is one of four operations: check out a free lock, force a lock's state true, force it false, or hand a lock back to the pool.

Each lock carries two bits: an allocated bit, which records whether the lock has been checked out, and a state bit, which is the semaphore value itself. The set and clear operations are atomic read-modify-write actions. Each returns the state the lock held just before the request, so a core can use set as a test-and-set primitive. A check-out returns the lowest-numbered free lock. When every lock is taken, it returns a failure flag and an all-ones ID.

Top module: `lock_pool`

## Requirements
- R1: The pool holds NUM_LOCKS locks (default 8, IDs 0 to 7). `req_op` is encoded as 0 = allocate, 1 = set, 2 = clear and 3 = release. `req_id` selects the lock for set, clear and release.
- R2: An allocate request with at least one free lock returns the lowest free lock ID in `resp_id`, with bit 3 of `resp_id` at 0. It marks that lock allocated and returns `resp_fail` = 0.
- R3: An allocate request when no lock is free returns `resp_fail` = 1 and `resp_id` = 4'b1111, which stands for -1. It changes no lock.
- R4: A set request makes the addressed lock's state true and returns its previous state in `resp_prior`. `resp_id` echoes the request ID.
- R5: A clear request makes the addressed lock's state false and returns its previous state in `resp_prior`.
- R6: A release request frees the addressed lock, so that a later allocate can return it again. The release leaves the lock's state bit unchanged.
- R7: Set and clear act on a lock's state whether or not that lock is allocated.
- R8: Synchronous active-high reset clears every allocated bit and every state bit. While reset is applied, `resp_valid` reads 0.
- R9: A request takes effect in one cycle. Its result appears with `resp_valid` = 1 on the cycle after the request. A cycle with no request gives `resp_valid` = 0 on the next cycle, with `resp_prior` and `resp_fail` at 0. For allocate and release, `resp_prior` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation code |
| req_id | input | 3 | Target lock for set, clear and release |
| resp_valid | output | 1 | Result of the previous cycle's request |
| resp_id | output | 4 | Allocated or echoed lock ID; all ones on allocate failure |
| resp_prior | output | 1 | Lock state before a set or clear |
| resp_fail | output | 1 | Allocate found no free lock |

## Verification
The assertions check several properties on every cycle. After a set or clear, the addressed state bit holds the new value. A successful allocate marks the returned lock allocated. A release leaves every state bit untouched. A failure always carries the all-ones ID. An allocate when lock 0 is free returns ID 0. Other behaviours show only in the bench's scenarios: lowest-first order as locks are released and taken again, exhaustion after eight allocations, test-and-set sequences on unallocated locks, and the full clearing of the pool by a mid-run reset. The random mix compares every response with a bench model.

// File: rtl/lock_pool_pkg.sv
package lock_pool_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_SET     = 2'd1,
    OP_CLEAR   = 2'd2,
    OP_RELEASE = 2'd3
  } lock_op_e;
endpackage

// File: rtl/lock_prio_find.sv
module lock_prio_find #(
  parameter int NUM_LOCKS = 8,
  parameter int ID_W      = $clog2(NUM_LOCKS)
) (
  input  logic [NUM_LOCKS-1:0] free_mask,
  output logic                 found,
  output logic [ID_W-1:0]      idx
);
  // Scan from the top down so the lowest free index wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_LOCKS - 1; i >= 0; i--) begin
      if (free_mask[i]) begin
        found = 1'b1;
        idx   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/lock_bank.sv
module lock_bank
  import lock_pool_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int ID_W      = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  lock_op_e             op,
  input  logic [ID_W-1:0]      tgt_id,
  input  logic                 grant_hit,
  input  logic [ID_W-1:0]      grant_id,
  output logic [NUM_LOCKS-1:0] alloc_q,
  output logic [NUM_LOCKS-1:0] state_q
);
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic hit_tgt, hit_grant;
    assign hit_tgt   = (tgt_id == ID_W'(g));
    assign hit_grant = grant_hit && (grant_id == ID_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        alloc_q[g] <= 1'b0;
        state_q[g] <= 1'b0;
      end else if (op_valid) begin
        case (op)
          OP_ALLOC:   if (hit_grant) alloc_q[g] <= 1'b1;
          OP_SET:     if (hit_tgt)   state_q[g] <= 1'b1;
          OP_CLEAR:   if (hit_tgt)   state_q[g] <= 1'b0;
          OP_RELEASE: if (hit_tgt)   alloc_q[g] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R4 / R7: a set leaves the addressed state true.
  p_set_state_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_SET) |=> state_q[$past(tgt_id)]);
  // R5: a clear leaves the addressed state false.
  p_clear_state_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_CLEAR) |=> !state_q[$past(tgt_id)]);
  // R6: a release never disturbs any state bit.
  p_release_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_RELEASE) |=> $stable(state_q));
  // R2: a granted lock is marked allocated.
  p_grant_marks_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_ALLOC && grant_hit) |=> alloc_q[$past(grant_id)]);
  // R3: a failed allocate changes no allocated bit.
  p_fail_no_change_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_ALLOC && !grant_hit) |=> $stable(alloc_q));
endmodule

// File: rtl/lock_pool.sv
module lock_pool
  import lock_pool_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  localparam int ID_W     = $clog2(NUM_LOCKS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [ID_W-1:0] req_id,
  output logic            resp_valid,
  output logic [ID_W:0]   resp_id,
  output logic            resp_prior,
  output logic            resp_fail
);
  lock_op_e            op;
  logic [NUM_LOCKS-1:0] alloc_q, state_q;
  logic                 grant_hit;
  logic [ID_W-1:0]      grant_id;

  assign op = lock_op_e'(req_op);

  lock_prio_find #(.NUM_LOCKS(NUM_LOCKS), .ID_W(ID_W)) u_find (
    .free_mask(~alloc_q),
    .found    (grant_hit),
    .idx      (grant_id)
  );

  lock_bank #(.NUM_LOCKS(NUM_LOCKS), .ID_W(ID_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .op_valid (req_valid),
    .op       (op),
    .tgt_id   (req_id),
    .grant_hit(grant_hit),
    .grant_id (grant_id),
    .alloc_q  (alloc_q),
    .state_q  (state_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_id    <= '0;
      resp_prior <= 1'b0;
      resp_fail  <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_id    <= '0;
      resp_prior <= 1'b0;
      resp_fail  <= 1'b0;
      if (req_valid) begin
        case (op)
          OP_ALLOC: begin
            resp_id   <= grant_hit ? {1'b0, grant_id} : '1;
            resp_fail <= !grant_hit;
          end
          OP_SET, OP_CLEAR: begin
            resp_id    <= {1'b0, req_id};
            resp_prior <= state_q[req_id];
          end
          default: resp_id <= {1'b0, req_id};
        endcase
      end
    end
  end

  // R3: a failure always reports the all-ones ID on a valid response.
  p_fail_id_r3: assert property (@(posedge clk) disable iff (rst)
    resp_fail |-> (resp_valid && resp_id == '1));
  // R2: with lock 0 free, an allocate returns ID 0.
  p_first_free_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_ALLOC && !alloc_q[0]) |=> (resp_id == '0 && !resp_fail));
  // R9: a response follows each request by exactly one cycle.
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
endmodule

// File: tb/lock_pool_test.sv
module lock_pool_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_op;
  logic [2:0] req_id;
  logic       resp_valid;
  logic [3:0] resp_id;
  logic       resp_prior;
  logic       resp_fail;

  int checks = 0;
  int failures = 0;
  bit m_alloc[8];
  bit m_state[8];

  always #4 clk = ~clk;

  lock_pool uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_id(req_id),
    .resp_valid(resp_valid), .resp_id(resp_id), .resp_prior(resp_prior), .resp_fail(resp_fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 8; i++) if (!m_alloc[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_alloc[i] = 0; m_state[i] = 0; end
  endtask

  // Drive one request, then check its response after the next rising edge (R9).
  task automatic do_op(input logic [1:0] op, input logic [2:0] id, input string req);
    logic [3:0] e_id;
    bit e_prior, e_fail;
    int f;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_id = id;
    e_prior = 0; e_fail = 0; e_id = {1'b0, id};
    case (op)
      2'd0: begin
        f = lowest_free();
        if (f < 0) begin e_fail = 1; e_id = 4'hF; end
        else begin e_id = 4'(f); m_alloc[f] = 1; end
      end
      2'd1: begin e_prior = m_state[id]; m_state[id] = 1; end
      2'd2: begin e_prior = m_state[id]; m_state[id] = 0; end
      default: m_alloc[id] = 0;
    endcase
    @(posedge clk); #2;
    check(resp_valid == 1'b1, {req, " R9 valid"}, int'(resp_valid), 1);
    check(resp_id == e_id, {req, " id"}, int'(resp_id), int'(e_id));
    check(resp_prior == e_prior, {req, " prior"}, int'(resp_prior), int'(e_prior));
    check(resp_fail == e_fail, {req, " fail"}, int'(resp_fail), int'(e_fail));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #2;
    check(resp_valid == 1'b0 && resp_fail == 1'b0 && resp_prior == 1'b0,
          "R9 idle no response", int'(resp_valid), 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check(resp_valid == 1'b0, "R8 resp_valid in reset", int'(resp_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_id = 3'd0;
    model_reset();
    apply_reset();

    // R1 R2: eight allocations hand out 0..7 in order.
    for (int i = 0; i < 8; i++) do_op(2'd0, 3'd0, "R2 alloc order");
    // R3: ninth allocation fails with all-ones ID.
    do_op(2'd0, 3'd0, "R3 alloc exhausted");
    // R6: release 3 and 5, allocate returns 3 then 5.
    do_op(2'd3, 3'd5, "R6 release");
    do_op(2'd3, 3'd3, "R6 release");
    do_op(2'd0, 3'd0, "R6 realloc lowest");
    do_op(2'd0, 3'd0, "R6 realloc next");
    do_op(2'd0, 3'd0, "R3 exhausted again");
    idle();
    // R4 R5: test-and-set sequence.
    do_op(2'd1, 3'd2, "R4 set from 0");
    do_op(2'd1, 3'd2, "R4 set from 1");
    do_op(2'd2, 3'd2, "R5 clear from 1");
    do_op(2'd2, 3'd2, "R5 clear from 0");
    // R6: release keeps state.
    do_op(2'd1, 3'd6, "R4 set lock 6");
    do_op(2'd3, 3'd6, "R6 release 6");
    do_op(2'd1, 3'd6, "R6 state kept after release");
    // R8: reset clears everything.
    apply_reset();
    do_op(2'd1, 3'd6, "R8 state cleared by reset");
    do_op(2'd0, 3'd0, "R8 alloc cleared by reset");
    // R7: set/clear on an unallocated lock.
    do_op(2'd1, 3'd7, "R7 set unallocated");
    do_op(2'd2, 3'd7, "R7 clear unallocated");
    do_op(2'd0, 3'd0, "R7 alloc unaffected by set");

    // Random mix, model-checked.
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) idle();
      else if (r <= 3) do_op(2'd0, 3'd0, "R2 random alloc");
      else do_op(2'($urandom_range(1, 3)), 3'($urandom_range(0, 7)), "R4 random op");
    end
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule